// File: doc/BRIEF.md
# Load-Store Effective Address Generator

This block forms the memory address for a load-store processor from a small addressing-mode code, the access size and the register values the mode needs. Short displacement fields taken from the instruction are zero-extended and scaled by the access size before they are added. Post-increment and pre-decrement modes also return the modified base register value, with a write-back strobe. The register file stores that value. The same stage extends the 8-bit instruction immediates for the ALU and sign-extends byte and word load data to full width.

All results are registered. Inputs presented with `in_valid` high in one cycle appear on the outputs one clock later, with `out_valid` high. A misalignment flag reports word accesses at odd addresses and long accesses at addresses that are not a multiple of four. A parameter can remove this flag.

Top module: `eag_top`

## Requirements
- R1: Mode code 0 (register indirect) and reserved mode code 7 give `ea` equal to `base`, with `base_new` equal to `base` and `wb_en` low.
- R2: Mode code 1 (post-increment) gives `ea` equal to `base` and `base_new` equal to `base` plus the step. The step is 1 for size code 0 (byte), 2 for size code 1 (word) and 4 for size codes 2 and 3 (long).
- R3: Mode code 2 (pre-decrement) gives `ea` and `base_new` both equal to `base` minus the step, wrapping modulo 2^32.
- R4: Mode code 3 zero-extends bits [3:0] of `disp` and scales them by 1, 2 or 4 for byte, word or long. The result is added to `base`. Bits [7:4] of `disp` have no effect.
- R5: Mode code 4 gives `ea` equal to `base` plus `index`, with no scaling.
- R6: Mode code 5 zero-extends the 8-bit `disp`, scales it by size and adds it to `gbase`.
- R7: Mode code 6 zero-extends the 8-bit `disp`, scales it by size and adds it to `pc`. For long accesses, `pc` bits [1:0] are cleared before the add.
- R8: `out_valid` equals `in_valid` one cycle earlier. `wb_en` is high only when `out_valid` is high and the mode was 1 or 2.
- R9: `misalign` is high for a valid word access with `ea[0]` set, or a valid long access with `ea[1:0]` nonzero. It is never high for byte accesses.
- R10: With `imm_kind` 0 (logic/test) or 3, `imm_ext` is the zero-extended `imm8`. With `imm_kind` 1 (move/add/compare-equal), it is the sign-extended `imm8`.
- R11: With `imm_kind` 2 (trap), `imm_ext` is the zero-extended `imm8` multiplied by 4.
- R12: `ld_ext` sign-extends `ld_raw[7:0]` for byte size and `ld_raw[15:0]` for word size, and passes `ld_raw` unchanged for long.
- R13: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| mode | input | 3 | Addressing-mode code |
| size | input | 2 | Access size code |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| gbase | input | 32 | Global base register value |
| pc | input | 32 | Program counter |
| disp | input | 8 | Raw displacement field |
| imm8 | input | 8 | Raw 8-bit immediate |
| imm_kind | input | 2 | Immediate extension kind |
| ld_raw | input | 32 | Raw load data |
| out_valid | output | 1 | Results valid |
| ea | output | 32 | Effective address |
| base_new | output | 32 | Updated base register value |
| wb_en | output | 1 | Base write-back enable |
| misalign | output | 1 | Misaligned access flag |
| imm_ext | output | 32 | Extended immediate |
| ld_ext | output | 32 | Extended load data |

## Verification
The hardest cases to reach are the arithmetic edges: a pre-decrement that wraps below zero, a displacement whose ignored upper nibble is set, and a PC-relative long access from a PC with low bits set. Each of these is placed directly in the vector table with a hand-computed address, for example base 0 with byte pre-decrement and PC 0x1006 with a long displacement. Misaligned and aligned results are paired across post-increment and indexed vectors, so that the flag is seen both high and low for each size.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [2:0] {
      MD_IND     = 3'd0,
      MD_POSTINC = 3'd1,
      MD_PREDEC  = 3'd2,
      MD_DISP4   = 3'd3,
      MD_INDEX   = 3'd4,
      MD_GDISP   = 3'd5,
      MD_PCDISP  = 3'd6,
      MD_RSVD    = 3'd7
   } mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_LALT = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      IK_LOGIC = 2'd0,
      IK_ARITH = 2'd1,
      IK_TRAP  = 2'd2,
      IK_ALT   = 2'd3
   } immk_e;

   function automatic logic [1:0] size_shift(input size_e s);
      case (s)
         SZ_BYTE: size_shift = 2'd0;
         SZ_WORD: size_shift = 2'd1;
         default: size_shift = 2'd2;
      endcase
   endfunction
endpackage

// File: rtl/eag_scale.sv
module eag_scale #(
   parameter int IN_W  = 4,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  raw,
   input  eag_pkg::size_e   size,
   output logic [OUT_W-1:0] scaled
);
   localparam int PAD_W = OUT_W - IN_W;

   if (IN_W < 1 || PAD_W < 2) begin : g_bad_width
      $error("eag_scale: OUT_W must exceed IN_W by at least 2");
   end

   logic [OUT_W-1:0] zext;
   assign zext = {{PAD_W{1'b0}}, raw};

   always_comb begin
      scaled = zext << eag_pkg::size_shift(size);
   end
endmodule

// File: rtl/eag_addr.sv
module eag_addr #(
   parameter int AW   = 32,
   parameter int SD_W = 4,
   parameter int LD_W = 8,
   parameter bit PC_LONG_MASK = 1'b1
) (
   input  eag_pkg::mode_e  mode,
   input  eag_pkg::size_e  size,
   input  logic [AW-1:0]   base,
   input  logic [AW-1:0]   index,
   input  logic [AW-1:0]   gbase,
   input  logic [AW-1:0]   pc,
   input  logic [LD_W-1:0] disp,
   output logic [AW-1:0]   ea,
   output logic [AW-1:0]   base_new,
   output logic            wb
);
   import eag_pkg::*;

   if (SD_W >= LD_W) begin : g_bad_disp
      $error("eag_addr: short displacement must be narrower than long one");
   end

   logic [AW-1:0] step, off_short, off_long, pc_base, post_val, pre_val;
   logic          is_long;

   eag_scale #(.IN_W(1),    .OUT_W(AW)) u_step  (.raw(1'b1),          .size(size), .scaled(step));
   eag_scale #(.IN_W(SD_W), .OUT_W(AW)) u_short (.raw(disp[SD_W-1:0]), .size(size), .scaled(off_short));
   eag_scale #(.IN_W(LD_W), .OUT_W(AW)) u_long  (.raw(disp),          .size(size), .scaled(off_long));

   assign is_long = (size == SZ_LONG) || (size == SZ_LALT);

   if (PC_LONG_MASK) begin : g_pc_mask
      assign pc_base = is_long ? {pc[AW-1:2], 2'b00} : pc;
   end else begin : g_pc_plain
      assign pc_base = pc;
   end

   assign post_val = base + step;
   assign pre_val  = base - step;

   always_comb begin
      ea       = base;
      base_new = base;
      wb       = 1'b0;
      case (mode)
         MD_POSTINC: begin
            base_new = post_val;
            wb       = 1'b1;
         end
         MD_PREDEC: begin
            ea       = pre_val;
            base_new = pre_val;
            wb       = 1'b1;
         end
         MD_DISP4:  ea = base + off_short;
         MD_INDEX:  ea = base + index;
         MD_GDISP:  ea = gbase + off_long;
         MD_PCDISP: ea = pc_base + off_long;
         default:   ea = base;
      endcase
   end
endmodule

// File: rtl/eag_imm.sv
module eag_imm #(
   parameter int DW = 32,
   parameter int IW = 8
) (
   input  logic [IW-1:0]   imm8,
   input  eag_pkg::immk_e  kind,
   input  eag_pkg::size_e  size,
   input  logic [DW-1:0]   ld_raw,
   output logic [DW-1:0]   imm_ext,
   output logic [DW-1:0]   ld_ext
);
   import eag_pkg::*;

   localparam int HW = 16;

   if (DW < 2 * HW || IW + 2 > DW) begin : g_bad_width
      $error("eag_imm: data width too small");
   end

   logic [DW-1:0] imm_z, imm_s;
   assign imm_z = {{(DW-IW){1'b0}}, imm8};
   assign imm_s = {{(DW-IW){imm8[IW-1]}}, imm8};

   always_comb begin
      case (kind)
         IK_ARITH: imm_ext = imm_s;
         IK_TRAP:  imm_ext = imm_z << 2;
         default:  imm_ext = imm_z;
      endcase
   end

   always_comb begin
      case (size)
         SZ_BYTE: ld_ext = {{(DW-8){ld_raw[7]}}, ld_raw[7:0]};
         SZ_WORD: ld_ext = {{(DW-HW){ld_raw[HW-1]}}, ld_raw[HW-1:0]};
         default: ld_ext = ld_raw;
      endcase
   end
endmodule

// File: rtl/eag_top.sv
module eag_top #(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int SD_W = 4,
   parameter int LD_W = 8,
   parameter int IW   = 8,
   parameter bit MISALIGN_EN  = 1'b1,
   parameter bit PC_LONG_MASK = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [2:0]      mode,
   input  logic [1:0]      size,
   input  logic [AW-1:0]   base,
   input  logic [AW-1:0]   index,
   input  logic [AW-1:0]   gbase,
   input  logic [AW-1:0]   pc,
   input  logic [LD_W-1:0] disp,
   input  logic [IW-1:0]   imm8,
   input  logic [1:0]      imm_kind,
   input  logic [DW-1:0]   ld_raw,
   output logic            out_valid,
   output logic [AW-1:0]   ea,
   output logic [AW-1:0]   base_new,
   output logic            wb_en,
   output logic            misalign,
   output logic [DW-1:0]   imm_ext,
   output logic [DW-1:0]   ld_ext
);
   import eag_pkg::*;

   if (AW < 16) begin : g_bad_aw
      $error("eag_top: AW must be at least 16");
   end

   mode_e md;
   size_e sz;
   immk_e ik;
   assign md = mode_e'(mode);
   assign sz = size_e'(size);
   assign ik = immk_e'(imm_kind);

   logic [AW-1:0] ea_c, bn_c;
   logic          wb_c, mis_c;
   logic [DW-1:0] imm_c, ld_c;

   eag_addr #(.AW(AW), .SD_W(SD_W), .LD_W(LD_W), .PC_LONG_MASK(PC_LONG_MASK)) u_addr (
      .mode(md), .size(sz), .base(base), .index(index), .gbase(gbase),
      .pc(pc), .disp(disp), .ea(ea_c), .base_new(bn_c), .wb(wb_c)
   );

   eag_imm #(.DW(DW), .IW(IW)) u_imm (
      .imm8(imm8), .kind(ik), .size(sz), .ld_raw(ld_raw),
      .imm_ext(imm_c), .ld_ext(ld_c)
   );

   if (MISALIGN_EN) begin : g_mis
      always_comb begin
         case (sz)
            SZ_BYTE: mis_c = 1'b0;
            SZ_WORD: mis_c = ea_c[0];
            default: mis_c = |ea_c[1:0];
         endcase
      end
   end else begin : g_nomis
      assign mis_c = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ea        <= '0;
         base_new  <= '0;
         wb_en     <= 1'b0;
         misalign  <= 1'b0;
         imm_ext   <= '0;
         ld_ext    <= '0;
      end else begin
         out_valid <= in_valid;
         wb_en     <= in_valid & wb_c;
         misalign  <= in_valid & mis_c;
         if (in_valid) begin
            ea       <= ea_c;
            base_new <= bn_c;
            imm_ext  <= imm_c;
            ld_ext   <= ld_c;
         end
      end
   end
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter bit MISALIGN_EN = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [2:0]    mode,
   input logic [1:0]    size,
   input logic [AW-1:0] base,
   input logic [1:0]    imm_kind,
   input logic          out_valid,
   input logic [AW-1:0] ea,
   input logic [AW-1:0] base_new,
   input logic          wb_en,
   input logic          misalign,
   input logic [DW-1:0] imm_ext
);
   logic [AW-1:0] step_q;
   logic [2:0]    mode_q;
   logic [1:0]    size_q;
   logic [1:0]    kind_q;
   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      mode_q <= mode;
      size_q <= size;
      kind_q <= imm_kind;
      base_q <= base;
      step_q <= (size == 2'd0) ? AW'(1) : (size == 2'd1) ? AW'(2) : AW'(4);
   end

   // R8
   p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));
   p_wb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> out_valid && (mode_q == 3'd1 || mode_q == 3'd2));
   // R1
   p_indirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && mode_q == 3'd0 |-> ea == base_q && base_new == base_q && !wb_en);
   // R2
   p_postinc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && mode_q == 3'd1 |-> ea == base_q && (base_new - ea) == step_q && wb_en);
   // R3
   p_predec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && mode_q == 3'd2 |-> ea == base_new && (base_q - ea) == step_q && wb_en);
   // R9
   p_mis_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && size_q == 2'd0 |-> !misalign);
   p_mis_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
      MISALIGN_EN && out_valid && size_q[1] && ea[1:0] != 2'b00 |-> misalign);
   // R11
   p_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && kind_q == 2'd2 |-> imm_ext[1:0] == 2'b00 && imm_ext[DW-1:10] == '0);
endmodule

bind eag_top eag_chk #(.AW(AW), .DW(DW), .MISALIGN_EN(MISALIGN_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .size(size),
   .base(base), .imm_kind(imm_kind), .out_valid(out_valid), .ea(ea),
   .base_new(base_new), .wb_en(wb_en), .misalign(misalign), .imm_ext(imm_ext)
);

// File: tb/eag_top_tb.sv
module eag_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  size = '0;
   logic [31:0] base = '0, index = '0, gbase = '0, pc = '0;
   logic [7:0]  disp = '0, imm8 = '0;
   logic [1:0]  imm_kind = '0;
   logic [31:0] ld_raw = '0;
   logic        out_valid, wb_en, misalign;
   logic [31:0] ea, base_new, imm_ext, ld_ext;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   eag_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .size(size),
      .base(base), .index(index), .gbase(gbase), .pc(pc), .disp(disp),
      .imm8(imm8), .imm_kind(imm_kind), .ld_raw(ld_raw),
      .out_valid(out_valid), .ea(ea), .base_new(base_new), .wb_en(wb_en),
      .misalign(misalign), .imm_ext(imm_ext), .ld_ext(ld_ext)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic [2:0]  md;
      logic [1:0]  sz;
      logic [31:0] b, ix, gb, p;
      logic [7:0]  d;
      logic [31:0] x_ea, x_bn;
      logic        x_wb, x_mis;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{8'd1, 3'd0, 2'd2, 32'h2000_0010, 32'h0, 32'h0, 32'h0, 8'h00, 32'h2000_0010, 32'h2000_0010, 1'b0, 1'b0}, // R1
      '{8'd2, 3'd1, 2'd1, 32'h0000_0100, 32'h0, 32'h0, 32'h0, 8'h00, 32'h0000_0100, 32'h0000_0102, 1'b1, 1'b0}, // R2
      '{8'd2, 3'd1, 2'd2, 32'h0000_0202, 32'h0, 32'h0, 32'h0, 8'h00, 32'h0000_0202, 32'h0000_0206, 1'b1, 1'b1}, // R2 R9
      '{8'd3, 3'd2, 2'd0, 32'h0000_0000, 32'h0, 32'h0, 32'h0, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R3 wrap
      '{8'd3, 3'd2, 2'd2, 32'h0000_0400, 32'h0, 32'h0, 32'h0, 8'h00, 32'h0000_03FC, 32'h0000_03FC, 1'b1, 1'b0}, // R3
      '{8'd4, 3'd3, 2'd1, 32'h0000_1000, 32'h0, 32'h0, 32'h0, 8'hFF, 32'h0000_101E, 32'h0000_1000, 1'b0, 1'b0}, // R4 upper nibble
      '{8'd4, 3'd3, 2'd2, 32'h0000_1000, 32'h0, 32'h0, 32'h0, 8'h0F, 32'h0000_103C, 32'h0000_1000, 1'b0, 1'b0}, // R4
      '{8'd5, 3'd4, 2'd0, 32'h0000_1000, 32'hFFFF_FFFF, 32'h0, 32'h0, 8'h00, 32'h0000_0FFF, 32'h0000_1000, 1'b0, 1'b0}, // R5
      '{8'd5, 3'd4, 2'd1, 32'h0000_0011, 32'h0, 32'h0, 32'h0, 8'h00, 32'h0000_0011, 32'h0000_0011, 1'b0, 1'b1}, // R5 R9
      '{8'd6, 3'd5, 2'd2, 32'h0, 32'h0, 32'h0000_8000, 32'h0, 8'hFF, 32'h0000_83FC, 32'h0, 1'b0, 1'b0}, // R6
      '{8'd6, 3'd5, 2'd0, 32'h0, 32'h0, 32'h0000_8000, 32'h0, 8'h80, 32'h0000_8080, 32'h0, 1'b0, 1'b0}, // R6
      '{8'd7, 3'd6, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0000_1006, 8'h02, 32'h0000_100C, 32'h0, 1'b0, 1'b0}, // R7 masked
      '{8'd7, 3'd6, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0000_1006, 8'h02, 32'h0000_100A, 32'h0, 1'b0, 1'b0}, // R7
      '{8'd1, 3'd7, 2'd1, 32'h0000_0055, 32'h0, 32'h0, 32'h0, 8'h00, 32'h0000_0055, 32'h0000_0055, 1'b0, 1'b1}  // R1 reserved
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive_ext(input logic [1:0] sz, input logic [1:0] kind, input logic [7:0] im, input logic [31:0] raw);
      @(negedge clk);
      in_valid = 1'b1; mode = 3'd0; size = sz; imm_kind = kind; imm8 = im; ld_raw = raw;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset state
      chk("R13", "out_valid", {31'b0, out_valid}, 32'h0);
      chk("R13", "ea", ea, 32'h0);
      chk("R13", "base_new", base_new, 32'h0);
      chk("R13", "flags", {29'b0, wb_en, misalign, 1'b0}, 32'h0);
      chk("R13", "imm_ext", imm_ext, 32'h0);
      chk("R13", "ld_ext", ld_ext, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string r;
         @(negedge clk);
         in_valid = 1'b1; mode = VECS[i].md; size = VECS[i].sz; base = VECS[i].b;
         index = VECS[i].ix; gbase = VECS[i].gb; pc = VECS[i].p; disp = VECS[i].d;
         @(negedge clk);
         in_valid = 1'b0;
         r = $sformatf("R%0d", VECS[i].req);
         chk(r, "ea", ea, VECS[i].x_ea);
         chk(r, "base_new", base_new, VECS[i].x_bn);
         chk("R8", "wb_en", {31'b0, wb_en}, {31'b0, VECS[i].x_wb});
         chk("R9", "misalign", {31'b0, misalign}, {31'b0, VECS[i].x_mis});
         chk("R8", "out_valid", {31'b0, out_valid}, 32'h1);
      end

      // R8: idle cycle after a post-increment request
      @(negedge clk);
      in_valid = 1'b1; mode = 3'd1; size = 2'd2; base = 32'h40;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R8", "idle out_valid", {31'b0, out_valid}, 32'h0);
      chk("R8", "idle wb_en", {31'b0, wb_en}, 32'h0);
      chk("R9", "idle misalign", {31'b0, misalign}, 32'h0);

      // R10 / R11 / R12
      drive_ext(2'd0, 2'd0, 8'h80, 32'h1234_5680);
      chk("R10", "logic zext", imm_ext, 32'h0000_0080);
      chk("R12", "byte sext", ld_ext, 32'hFFFF_FF80);
      drive_ext(2'd1, 2'd1, 8'h80, 32'h0000_8001);
      chk("R10", "arith sext neg", imm_ext, 32'hFFFF_FF80);
      chk("R12", "word sext neg", ld_ext, 32'hFFFF_8001);
      drive_ext(2'd1, 2'd1, 8'h7F, 32'hABCD_7FFF);
      chk("R10", "arith sext pos", imm_ext, 32'h0000_007F);
      chk("R12", "word sext pos", ld_ext, 32'h0000_7FFF);
      drive_ext(2'd2, 2'd2, 8'hFF, 32'h8000_0001);
      chk("R11", "trap x4", imm_ext, 32'h0000_03FC);
      chk("R12", "long pass", ld_ext, 32'h8000_0001);
      drive_ext(2'd3, 2'd3, 8'hF0, 32'h0000_0080);
      chk("R10", "kind3 zext", imm_ext, 32'h0000_00F0);
      chk("R12", "size3 pass", ld_ext, 32'h0000_0080);

      // R13: reset asserted mid-run clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R13", "ea after reset", ea, 32'h0);
      chk("R13", "imm after reset", imm_ext, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule